// File: doc/BRIEF.md
# Serial Divide-by-Three Unit

This unit divides an unsigned binary number by three while the number streams in one bit per accepted cycle, most significant bit first. Its only state is the remainder of the prefix received so far. Each accepted bit moves the remainder to its next value and produces one quotient bit, so the quotient bits leave the unit in the same order as the dividend bits arrive.

The remainder is visible at all times, so the caller can tell whether the prefix seen so far is a multiple of three. The operand length has no upper limit. A new operand starts with a reset, which returns the remainder to zero. Cycles on which the strobe is low are idle cycles, and the caller may insert them anywhere in the stream.

Top module: `div3_serial_divider`

## Requirements
- R1: While rst_ni is low, rem_o is 0, quot_o is 0 and quot_valid_o is 0. The reset takes effect at once, even when a valid bit is presented in the same cycle.
- R2: When the remainder is 0 and a bit is accepted, quot_o becomes 0. An input bit of 0 leaves the remainder at 0, and an input bit of 1 moves it to 1.
- R3: When the remainder is 1 and a bit is accepted, an input bit of 0 moves the remainder to 2 with quot_o 0. An input bit of 1 moves the remainder to 0 with quot_o 1.
- R4: When the remainder is 2 and a bit is accepted, quot_o becomes 1. An input bit of 0 moves the remainder to 1, and an input bit of 1 leaves it at 2.
- R5: rem_o carries the remainder as a binary number (00, 01 or 10) and never shows 11.
- R6: On a cycle with valid_i low, rem_o and quot_o keep their values whatever din_i carries.
- R7: quot_valid_o equals valid_i delayed by one clock. quot_o and rem_o change on the same clock edge that accepts the bit.
- R8: For an operand of any length fed MSB first, the quot_o bits taken in order on the cycles when quot_valid_o is high form the operand divided by 3, and the final rem_o is the operand modulo 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the remainder |
| valid_i | input | 1 | Marks din_i as a dividend bit for this cycle |
| din_i | input | 1 | Serial dividend bit, MSB first |
| quot_o | output | 1 | Quotient bit produced by the last accepted bit |
| quot_valid_o | output | 1 | High for one cycle after each accepted bit |
| rem_o | output | 2 | Running remainder of the accepted prefix |

## Verification
Two events can fall in the same cycle. In the first, a reset lands while a valid dividend bit is being presented. The bench provokes this by pulling rst_ni low in the middle of an operand with valid_i still high and din_i at 1, and it judges that rem_o and quot_valid_o clear at once and stay clear across the edge. In the second, a bit is accepted in the same cycle that the quotient bit of the previous one is presented. Back-to-back strobes test this, and a behavioural remainder model compares every cycle. Each operand's collected quotient is also compared with integer division.

// File: rtl/div3_pkg.sv
package div3_pkg;
  localparam int unsigned REM_W = 2;

  typedef enum logic [REM_W-1:0] {
    REM_ZERO = 2'b00,
    REM_ONE  = 2'b01,
    REM_TWO  = 2'b10
  } rem_e;
endpackage

// File: rtl/div3_step_logic.sv
module div3_step_logic
  import div3_pkg::*;
#(
  parameter bit ARITH_FORM = 1'b1
) (
  input  rem_e rem_i,
  input  logic bit_i,
  output rem_e rem_nxt_o,
  output logic quot_nxt_o
);
  generate
    if (ARITH_FORM) begin : g_arith
      // {rem,bit} is 2*rem+bit; subtract 3 in two bits when it reaches 3
      logic [2:0] sum;
      logic [1:0] diff;
      assign sum  = {rem_i, bit_i};
      assign diff = sum[1:0] - 2'd3;
      always_comb begin
        quot_nxt_o = (sum >= 3'd3);
        rem_nxt_o  = quot_nxt_o ? rem_e'(diff) : rem_e'(sum[1:0]);
      end
    end else begin : g_table
      always_comb begin
        unique case (rem_i)
          REM_ZERO: begin rem_nxt_o = bit_i ? REM_ONE : REM_ZERO; quot_nxt_o = 1'b0; end
          REM_ONE:  begin rem_nxt_o = bit_i ? REM_ZERO : REM_TWO; quot_nxt_o = bit_i; end
          REM_TWO:  begin rem_nxt_o = bit_i ? REM_TWO : REM_ONE;  quot_nxt_o = 1'b1; end
          default:  begin rem_nxt_o = REM_ZERO; quot_nxt_o = 1'b0; end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/div3_en_reg.sv
module div3_en_reg #(
  parameter int unsigned         W       = 1,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/div3_serial_divider.sv
module div3_serial_divider
  import div3_pkg::*;
#(
  parameter bit ARITH_FORM = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             din_i,
  output logic             quot_o,
  output logic             quot_valid_o,
  output logic [REM_W-1:0] rem_o
);
  rem_e             rem_q, rem_nxt;
  logic             quot_nxt;
  logic [REM_W-1:0] rem_raw;

  div3_step_logic #(.ARITH_FORM(ARITH_FORM)) i_step (
    .rem_i     (rem_q),
    .bit_i     (din_i),
    .rem_nxt_o (rem_nxt),
    .quot_nxt_o(quot_nxt)
  );

  div3_en_reg #(.W(REM_W), .RST_VAL(REM_ZERO)) i_rem_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (rem_nxt),
    .q_o   (rem_raw)
  );
  assign rem_q = rem_e'(rem_raw);

  div3_en_reg #(.W(1), .RST_VAL(1'b0)) i_quot_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (quot_nxt),
    .q_o   (quot_o)
  );

  div3_en_reg #(.W(1), .RST_VAL(1'b0)) i_vld_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (1'b1),
    .d_i   (valid_i),
    .q_o   (quot_valid_o)
  );

  assign rem_o = rem_raw;

  assert_rem_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_o != 2'b11);

  assert_from_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rem_o == 2'b00) |=> (!quot_o && rem_o == {1'b0, $past(din_i)}));

  assert_from_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rem_o == 2'b01) |=> (quot_o == $past(din_i) &&
                                     rem_o == ($past(din_i) ? 2'b00 : 2'b10)));

  assert_from_two_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rem_o == 2'b10) |=> (quot_o && rem_o == ($past(din_i) ? 2'b10 : 2'b01)));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(rem_o) && $stable(quot_o)));

  assert_vld_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> quot_valid_o);

  assert_vld_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !quot_valid_o);
endmodule

// File: tb/test_div3_serial_divider.sv
module test_div3_serial_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       din_i = 1'b0;
  logic       quot_o, quot_valid_o;
  logic [1:0] rem_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_rem = 0;
  int m_q = 0;
  int m_qv = 0;
  longint unsigned q_acc;

  always #4 clk_i = ~clk_i;

  div3_serial_divider i_div3_serial_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .din_i(din_i),
    .quot_o(quot_o), .quot_valid_o(quot_valid_o), .rem_o(rem_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    chk("R1 rem", rem_o, 0);
    chk("R1 qvalid", quot_valid_o, 0);
    chk("R1 quot", quot_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_rem = 0; m_q = 0; m_qv = 0; q_acc = 0;
  endtask

  // one cycle: drive at negedge, model at posedge, compare 2 ns later
  task automatic step(input logic v, input logic b);
    string tag;
    int s;
    valid_i = v; din_i = b;
    tag = !v ? "R6" : (m_rem == 0) ? "R2" : (m_rem == 1) ? "R3" : "R4";
    @(posedge clk_i);
    m_qv = v;
    if (v) begin
      s = 2 * m_rem + int'(b);
      m_q = (s >= 3) ? 1 : 0;
      m_rem = s % 3;
    end
    #2;
    chk({tag, " rem"}, rem_o, m_rem);
    chk({tag, " quot"}, quot_o, m_q);
    chk("R7 qvalid", quot_valid_o, m_qv);
    chk("R5 rem legal", (rem_o == 2'b11), 0);
    if (quot_valid_o) q_acc = (q_acc << 1) | longint'(quot_o);
    @(negedge clk_i);
  endtask

  task automatic run_operand(input longint unsigned n, input int w, input bit gaps);
    do_reset();
    for (int i = w - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) step(1'b0, 1'($urandom));
      step(1'b1, n[i]);
    end
    step(1'b0, 1'b1);
    chk("R8 quotient", longint'(q_acc), longint'(n / 3));
    chk("R8 remainder", rem_o, longint'(n % 3));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    // all six transitions: 0,1,0,0,1 then 1,0,1,1
    step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b0);
    step(1'b1, 1'b0); step(1'b1, 1'b1);
    step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b1);
    // R6: idle cycles with toggling din must not disturb state
    step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b0, 1'b0);
    // R1: reset lands while a valid bit is presented
    valid_i = 1'b1; din_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 mid rem", rem_o, 0);
    chk("R1 mid qvalid", quot_valid_o, 0);
    @(posedge clk_i); #2;
    chk("R1 held rem", rem_o, 0);
    chk("R1 held qvalid", quot_valid_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1; valid_i = 1'b0;
    m_rem = 0; m_q = 0; m_qv = 0;
    // R8 boundary operands
    run_operand(64'd3, 2, 1'b0);
    run_operand(64'd1, 1, 1'b0);
    run_operand(64'hFFFF_FFFF, 32, 1'b0);
    run_operand(64'h8000_0000, 32, 1'b1);
    for (int k = 0; k < 40; k++) begin
      int w;
      longint unsigned n;
      w = 1 + int'($urandom % 32);
      n = longint'($urandom) & ((64'd1 << w) - 1);
      run_operand(n, w, k[0]);
    end
    finish_run();
  end
endmodule